// File: doc/BRIEF.md
# Event-Triggered Reload Timer

This block is an 8-bit down-counting timer for a contactless reader's protocol engine. A control register selects which protocol events start or stop the timer. A start event can be the beginning of a transmission, the end of a transmission, or a software command. A stop event can be the beginning of a reception, the end of a reception, or a software command. When a start event occurs, the counter takes the reload value and counts down. Each step is paced by a power-of-two prescaler running off the system clock. When the count runs out, the block emits an interrupt request pulse. It then either halts or, in auto-restart mode, reloads and keeps counting.

The sequencing sits in a two-state machine. In `ST_IDLE` the count is frozen. A start event moves the machine to `ST_RUN` and loads the counter. In `ST_RUN` the count changes as follows:

- A new start event reloads the counter and the machine stays in `ST_RUN`.
- A stop event returns the machine to `ST_IDLE` and keeps the count.
- An expiry with auto-restart off returns the machine to `ST_IDLE` with the count at zero.
- An expiry with auto-restart on stays in `ST_RUN` with a fresh reload.
- Any other prescaler tick lowers the count by one.

The transmit and receive events arrive as single-cycle pulses from the neighbouring framing logic. The interrupt pulse goes to an interrupt controller that lies outside this block.

Top module: `event_reload_timer`

## Requirements
- R1: After reset, `count_o` is 0, `running_o` is 0, `irq_o` is 0 and `ctrl_rd` reads 0x06.
- R2: The control register bits are: bit0 starts on transmit begin, bit1 starts on transmit end, bit2 stops on receive begin, bit3 stops on receive end, bit4 selects auto-restart, and bit5 is reserved. A start event is any of the following: `ev_tx_begin` with bit0 set, `ev_tx_end` with bit1 set, or a control write with bit6 set. In the cycle after a start event, `running_o` is 1 and `count_o` equals `reload_val`.
- R3: A stop event is any of the following: `ev_rx_begin` with bit2 set, `ev_rx_end` with bit3 set, or a control write with bit7 set. A stop event while running clears `running_o` in the next cycle, keeps `count_o`, and raises no interrupt.
- R4: An event whose enable bit is clear changes neither `count_o` nor `running_o`. While idle, the count is held.
- R5: While running, `count_o` decreases by one every 2^p clocks, where p = `prescale`. The first decrement comes 2^p clocks after the load.
- R6: With auto-restart off, the step from 1 to 0 gives a one-cycle `irq_o` pulse, and in that same cycle `count_o` is 0 and `running_o` is 0.
- R7: With auto-restart on, the step from 1 gives an `irq_o` pulse, and `count_o` takes `reload_val` while `running_o` stays 1.
- R8: A start event in the same cycle as a stop event wins. A start event while running reloads the counter.
- R9: A stop event in the same cycle as an expiring step wins, so no interrupt is raised.
- R10: Control bits 7:5 always read 0. Bits 6 and 7 act only in the write cycle and are not stored.
- R11: A reload value of 0 makes the counter wrap to 255, so 256 steps pass before expiry.
- R12: Prescaler values above `MAX_SHIFT` (default 21) act as `MAX_SHIFT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data, including the start and stop command bits |
| ctrl_rd | output | 8 | Control register readback |
| prescale | input | 5 | Prescaler exponent |
| reload_val | input | 8 | Value loaded on start and on auto-restart |
| ev_tx_begin | input | 1 | Transmit-begin pulse |
| ev_tx_end | input | 1 | Transmit-end pulse |
| ev_rx_begin | input | 1 | Receive-begin pulse |
| ev_rx_end | input | 1 | Receive-end pulse |
| count_o | output | 8 | Current count |
| running_o | output | 1 | Timer active |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
A wrong state bit shows up on `running_o` in the cycle after the edge where it goes wrong. It also shows up as a count that keeps moving while idle, or one that stays frozen while running. A wrong prescaler phase stays hidden until the next decrement, which is at most 2^p clocks later. A wrong comparison at expiry shows up within one step, as a missing or extra `irq_o`, or as a count that goes past zero. Because of this, the bench checks all four outputs on every cycle against its own model of the requirements. Short prescaler settings keep the time to detection to a few cycles.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    // control word layout (bit positions are decoded by software)
    typedef struct packed {
        logic stop_now;      // 7: write-only stop command
        logic start_now;     // 6: write-only start command
        logic rsvd;          // 5: reserved, reads 0
        logic auto_rst;      // 4: reload on expiry
        logic stop_rx_end;   // 3
        logic stop_rx_begin; // 2
        logic start_tx_end;  // 1
        logic start_tx_beg;  // 0
    } ctrl_word_t;

    localparam int CFG_BITS      = 5;
    localparam logic [CFG_BITS-1:0] CFG_RESET = 5'b00110;
    localparam int N_START_HW    = 2;
    localparam int N_STOP_HW     = 2;

endpackage

// File: rtl/evtmr_ctrl_reg.sv
module evtmr_ctrl_reg
    import evtmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [CFG_BITS-1:0] cfg,
    output logic                sw_start,
    output logic                sw_stop
);

    ctrl_word_t                 wr_word;
    logic [CFG_BITS-1:0]        cfg_q;
    logic                       unused_rsvd;

    assign wr_word     = ctrl_word_t'(wdata);
    assign unused_rsvd = wr_word.rsvd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= wdata[CFG_BITS-1:0];
        end
    end

    // command bits act only in the write cycle
    assign sw_start = we && wr_word.start_now;
    assign sw_stop  = we && wr_word.stop_now;

    assign cfg   = cfg_q;
    assign rdata = {{(8-CFG_BITS){1'b0}}, cfg_q};

endmodule

// File: rtl/evtmr_event_arb.sv
module evtmr_event_arb #(
    parameter int N_START = 2,
    parameter int N_STOP  = 2
) (
    input  logic [N_START-1:0] hw_start_ev,
    input  logic [N_START-1:0] hw_start_en,
    input  logic               sw_start,
    input  logic [N_STOP-1:0]  hw_stop_ev,
    input  logic [N_STOP-1:0]  hw_stop_en,
    input  logic               sw_stop,
    output logic               start_req,
    output logic               stop_req
);

    logic [N_START-1:0] start_hit;
    logic [N_STOP-1:0]  stop_hit;

    for (genvar gi = 0; gi < N_START; gi++) begin : g_start
        assign start_hit[gi] = hw_start_ev[gi] & hw_start_en[gi];
    end

    for (genvar gj = 0; gj < N_STOP; gj++) begin : g_stop
        assign stop_hit[gj] = hw_stop_ev[gj] & hw_stop_en[gj];
    end

    // start has priority over a simultaneous stop
    assign start_req = (|start_hit) | sw_start;
    assign stop_req  = ((|stop_hit) | sw_stop) & ~start_req;

endmodule

// File: rtl/evtmr_prescaler.sv
module evtmr_prescaler #(
    parameter int SHIFT_W   = 5,
    parameter int MAX_SHIFT = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               enable,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int PRE_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [SHIFT_W:0] eff_shift;
    logic [PRE_W:0]   mask_wide;
    logic [PRE_W-1:0] mask;

    always_comb begin
        if (int'(shift) > MAX_SHIFT) begin
            eff_shift = (SHIFT_W+1)'(MAX_SHIFT);
        end else begin
            eff_shift = {1'b0, shift};
        end
        mask_wide = ((PRE_W+1)'(1) << eff_shift) - (PRE_W+1)'(1);
        mask      = mask_wide[PRE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (enable) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign tick = enable && ((pre_q & mask) == mask);

endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
    import evtmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             tick,
    input  logic             auto_rst,
    input  logic [CNT_W-1:0] reload_val,
    output logic             load,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             expire;
    logic             dec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and step decisions
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        expire  = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (start_req) begin
                    load = 1'b1;
                end else if (stop_req) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    if (cnt_q == ONE) begin
                        expire = 1'b1;
                        if (!auto_rst) begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs: count and interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire;
            if (load) begin
                cnt_q <= reload_val;
            end else if (expire) begin
                cnt_q <= auto_rst ? reload_val : '0;
            end else if (dec) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count_o   = cnt_q;
    assign running_o = (state_q == ST_RUN);
    assign irq_o     = irq_q;

endmodule

// File: rtl/event_reload_timer.sv
module event_reload_timer
    import evtmr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHIFT_W   = 5,
    parameter int MAX_SHIFT = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [7:0]         ctrl_wdata,
    output logic [7:0]         ctrl_rd,
    input  logic [SHIFT_W-1:0] prescale,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic               ev_tx_begin,
    input  logic               ev_tx_end,
    input  logic               ev_rx_begin,
    input  logic               ev_rx_end,
    output logic [CNT_W-1:0]   count_o,
    output logic               running_o,
    output logic               irq_o
);

    logic [CFG_BITS-1:0] cfg;
    logic                sw_start;
    logic                sw_stop;
    logic                start_req;
    logic                stop_req;
    logic                tick;
    logic                load;

    evtmr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .rdata    (ctrl_rd),
        .cfg      (cfg),
        .sw_start (sw_start),
        .sw_stop  (sw_stop)
    );

    evtmr_event_arb #(
        .N_START (N_START_HW),
        .N_STOP  (N_STOP_HW)
    ) u_arb (
        .hw_start_ev ({ev_tx_end, ev_tx_begin}),
        .hw_start_en (cfg[1:0]),
        .sw_start    (sw_start),
        .hw_stop_ev  ({ev_rx_end, ev_rx_begin}),
        .hw_stop_en  (cfg[3:2]),
        .sw_stop     (sw_stop),
        .start_req   (start_req),
        .stop_req    (stop_req)
    );

    evtmr_prescaler #(
        .SHIFT_W   (SHIFT_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .enable (running_o),
        .shift  (prescale),
        .tick   (tick)
    );

    evtmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .tick       (tick),
        .auto_rst   (cfg[4]),
        .reload_val (reload_val),
        .load       (load),
        .count_o    (count_o),
        .running_o  (running_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl_rd,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             irq_o,
    input logic             start_req,
    input logic             stop_req
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> running_o && count_o == $past(reload_val)); // R2

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && running_o) |=> !running_o && !irq_o && $stable(count_o)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !start_req) |=> $stable(count_o) && !irq_o); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o) && !$past(start_req) && !irq_o) |->
        (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) - CNT_W'(1)))); // R5

    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(ctrl_rd[4])) |-> (!running_o && count_o == '0)); // R6

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(ctrl_rd[4])) |-> (running_o && count_o == $past(reload_val))); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[7:5] == 3'b000); // R10

endmodule

bind event_reload_timer evtmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rd    (ctrl_rd),
    .reload_val (reload_val),
    .count_o    (count_o),
    .running_o  (running_o),
    .irq_o      (irq_o),
    .start_req  (start_req),
    .stop_req   (stop_req)
);

// File: tb/event_reload_timer_test.sv
module event_reload_timer_test;

    localparam int MAXS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rd;
    logic [4:0] prescale = 5'd0;
    logic [7:0] reload_val = 8'd0;
    logic       ev_tx_begin = 1'b0;
    logic       ev_tx_end = 1'b0;
    logic       ev_rx_begin = 1'b0;
    logic       ev_rx_end = 1'b0;
    logic [7:0] count_o;
    logic       running_o;
    logic       irq_o;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // model state
    int          m_cnt = 0;
    bit          m_run = 0;
    bit          m_irq = 0;
    logic [7:0]  m_ctrl = 8'h06;
    longint      m_pre = 0;

    always #5 clk = ~clk;

    event_reload_timer #(.MAX_SHIFT(MAXS)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rd(ctrl_rd), .prescale(prescale), .reload_val(reload_val),
        .ev_tx_begin(ev_tx_begin), .ev_tx_end(ev_tx_end),
        .ev_rx_begin(ev_rx_begin), .ev_rx_end(ev_rx_end),
        .count_o(count_o), .running_o(running_o), .irq_o(irq_o)
    );

    function automatic longint period_of(int p);
        int e;
        e = (p > MAXS) ? MAXS : p;       // R12 clamp
        return longint'(1) << e;
    endfunction

    // advance the model by one clock from the inputs now applied
    task automatic model_next();
        bit st, sp, tk;
        longint per;
        st = (ev_tx_begin && m_ctrl[0]) || (ev_tx_end && m_ctrl[1]) || (ctrl_we && ctrl_wdata[6]);
        sp = (ev_rx_begin && m_ctrl[2]) || (ev_rx_end && m_ctrl[3]) || (ctrl_we && ctrl_wdata[7]);
        per = period_of(int'(prescale));
        tk = m_run && ((m_pre % per) == per - 1);
        m_irq = 0;
        if (st) begin
            m_cnt = int'(reload_val); m_run = 1; m_pre = 0;
        end else if (m_run) begin
            if (sp) begin
                m_run = 0;
            end else begin
                if (tk) begin
                    if (m_cnt == 1) begin
                        m_irq = 1;
                        if (m_ctrl[4]) m_cnt = int'(reload_val);
                        else begin m_cnt = 0; m_run = 0; end
                    end else begin
                        m_cnt = (m_cnt + 255) % 256;
                    end
                end
                m_pre++;
            end
        end
        if (ctrl_we) m_ctrl = {3'b000, ctrl_wdata[4:0]};
    endtask

    task automatic compare();
        checks++;
        if (count_o !== 8'(m_cnt) || running_o !== m_run || irq_o !== m_irq || ctrl_rd !== m_ctrl) begin
            fails++;
            $display("FAIL %s: count=%0d exp=%0d running=%0b exp=%0b irq=%0b exp=%0b ctrl=%h exp=%h",
                     cur_req, count_o, m_cnt, running_o, m_run, irq_o, m_irq, ctrl_rd, m_ctrl);
        end
    endtask

    task automatic step();
        model_next();
        @(negedge clk);
        compare();
        ev_tx_begin = 0; ev_tx_end = 0; ev_rx_begin = 0; ev_rx_end = 0;
        ctrl_we = 0; ctrl_wdata = 8'h00;
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_ctrl(logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        compare();

        // transmit-end start, one-shot expiry
        cur_req = "R2"; prescale = 0; reload_val = 8'd5;
        ev_tx_end = 1; step();
        cur_req = "R6"; run_cycles(8);

        // disabled events ignored
        cur_req = "R4"; ev_tx_begin = 1; step(); run_cycles(3);
        ev_tx_end = 1; step();
        ev_rx_end = 1; step(); run_cycles(2);
        cur_req = "R3"; ev_rx_begin = 1; step(); run_cycles(3);

        // prescaled stepping
        cur_req = "R5"; prescale = 2; reload_val = 8'd4;
        ev_tx_end = 1; step(); run_cycles(25);

        // auto-restart with software start, then software stop
        cur_req = "R7"; prescale = 1; reload_val = 8'd3;
        write_ctrl(8'h56); run_cycles(20);
        write_ctrl(8'h96); run_cycles(3);
        prescale = 0; reload_val = 8'd1; write_ctrl(8'h56); run_cycles(5);
        write_ctrl(8'h86); run_cycles(2);

        // start wins over stop, restart while running
        cur_req = "R8"; prescale = 0; reload_val = 8'd6;
        ev_tx_end = 1; ev_rx_begin = 1; step(); run_cycles(2);
        reload_val = 8'd9; ev_tx_end = 1; step(); run_cycles(3);
        ev_rx_begin = 1; step();

        // stop wins over expiry
        cur_req = "R9"; reload_val = 8'd2;
        ev_tx_end = 1; step(); step();
        ev_rx_begin = 1; step(); run_cycles(3);

        // reserved and command bits
        cur_req = "R10"; reload_val = 8'd7; write_ctrl(8'hFF); run_cycles(2);
        write_ctrl(8'hA6); run_cycles(2);

        // reload of zero wraps
        cur_req = "R11"; prescale = 0; reload_val = 8'd0;
        ev_tx_end = 1; step(); run_cycles(260);

        // clamp of prescaler
        cur_req = "R12"; prescale = 5'd9; reload_val = 8'd2;
        ev_tx_end = 1; step(); run_cycles(140);
        prescale = 5'd31; reload_val = 8'd1;
        ev_tx_end = 1; step(); run_cycles(70);

        // constrained random mix
        cur_req = "R5";
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(0, 15) == 0) ev_tx_begin = 1;
            if ($urandom_range(0, 15) == 0) ev_tx_end = 1;
            if ($urandom_range(0, 19) == 0) ev_rx_begin = 1;
            if ($urandom_range(0, 19) == 0) ev_rx_end = 1;
            if ($urandom_range(0, 39) == 0) begin
                ctrl_we = 1; ctrl_wdata = 8'($urandom_range(0, 255));
            end
            if ($urandom_range(0, 63) == 0) reload_val = 8'($urandom_range(0, 12));
            if ($urandom_range(0, 199) == 0)
                prescale = ($urandom_range(0, 9) == 0) ? 5'd20 : 5'($urandom_range(0, 3));
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule